// File: doc/BRIEF.md
# Event Timer Register Front End

This block is the register-access side of an event timer that owns one free-running 64-bit main count and a parameterised number of comparator timers. A 32-bit register bus reaches it with an address, read and write strobes, an access size in bytes and write data. Every register behind it is 64 bits wide. Address bit 2 picks which 32-bit half an access sees. The block stores the registers, returns read data one cycle after a read strobe, and runs the main count while the global run bit is set.

The address space has two parts. Offsets below 0x100 hold the global registers: identity and tick period, global control, event status and the main count. Offsets from 0x100 upward are cut into 32-byte slots, one slot per timer, and each slot holds a control word, a compare value and a route word. Writes merge only the addressed bit field into a register, and each register has its own mask of writable bits. Offsets that map to nothing read as zero and ignore writes.

Comparator match logic, periodic reload and interrupt delivery sit outside this block. It takes per-timer event pulses in. It drives the stored control, compare and route words and the running count out to that logic.

Top module: `evt_timer_regs`

## Requirements
- R1: A read strobe loads `bus_rdata` on the next clock edge with the addressed 64-bit register shifted right by 32 when address bit 2 is set. The lower 32 bits are taken. `bus_rdata` holds its value in cycles without a read strobe.
- R2: The identity register at 0x000 is read-only. Its low word reads 0x00000001 (revision 1). Its high word at 0x004 reads the tick period in femtoseconds, 10,000,000 (0x00989680) by default.
- R3: Global control at 0x010 keeps only bits 1:0 (write mask 0x3). Bit 0 is the run bit, driven on `tmr_run`. Bit 1 is legacy routing, driven on `tmr_legacy`. All other bits read zero.
- R4: For offsets 0x100 to 0x3FF, the timer index is (offset − 0x100) / 0x20. Within a slot, with bit 2 cleared, 0x00 selects control, 0x08 selects compare and 0x10 selects route. Compare and route are fully writable.
- R5: Timer control has write mask 0x7F4E. Bits 4 and 5 read as 1, bit 15 reads as 0, and bits 63:32 read the route capability, 0x000000F0 by default. All of these ignore writes.
- R6: A write updates only the field that starts at bit 0 (bit 2 clear) or bit 32 (bit 2 set). The field length is min(size × 8, 64 − start). A byte write changes only bits 7:0 of the addressed half.
- R7: Unmapped offsets read zero and ignore writes. This covers global offsets other than the four registers, slot offset 0x18, and any timer index at or above N (default 3, so 0x160 and up).
- R8: Event status at 0x020 has one bit per timer. A `tmr_hit` pulse sets the bit. Writing 1 clears it and writing 0 leaves it. A set in the same cycle wins over a clear. Bits N and up read zero.
- R9: While the run bit is set, the main count increases by one every cycle. A read of 0x0F0 returns the count as it stands at the read strobe.
- R10: A write to the main count takes effect only while the run bit is clear. A stopped count keeps and returns its last value.
- R11: After reset, global control, status, compare, route, the count and the writable control bits are all zero. The read-only fields hold their constants.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 10 | Byte offset of the access |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_size | input | 3 | Access size in bytes |
| bus_wdata | input | 32 | Write data |
| tmr_hit | input | N | Per-timer event pulses that set status bits |
| bus_rdata | output | 32 | Registered read data |
| tmr_run | output | 1 | Global run bit |
| tmr_legacy | output | 1 | Global legacy routing bit |
| main_count | output | 64 | Current main count |
| tmr_cfg_flat | output | 64*N | Timer control words, timer 0 in the low bits |
| tmr_cmp_flat | output | 64*N | Timer compare values |
| tmr_route_flat | output | 64*N | Timer route words |

## Verification
Read data appears at the first clock edge after the read strobe. The bench therefore checks `bus_rdata` at the falling edge that follows that edge. Write effects, status sets and run-bit changes become visible one edge after their strobe. Reads are issued only after that edge. The running count changes every edge, so the bench counts edges from the strobe of the run-bit write to each count read or stop. It derives the expected count from those edge counts.

// File: rtl/evt_pkg.sv
package evt_pkg;

    localparam int ADDR_W = 10;
    localparam int IDX_W  = ADDR_W - 5;

    localparam logic [63:0] GCFG_WMASK = 64'h0000_0000_0000_0003;
    localparam logic [63:0] TCFG_WMASK = 64'h0000_0000_0000_7F4E;
    localparam logic [63:0] FULL_WMASK = '1;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_IDENT,
        SEL_GCTL,
        SEL_STAT,
        SEL_COUNT,
        SEL_TCTL,
        SEL_TCMP,
        SEL_TROUTE
    } reg_sel_e;

    typedef struct packed {
        reg_sel_e           sel;
        logic [IDX_W-1:0]   tidx;
        logic               hi;
        logic [63:0]        fmask;
    } acc_dec_t;

    // Bit field touched by a write: starts at the half's shift,
    // length limited by the access size and the top of the register.
    function automatic logic [63:0] field_mask(input logic hi, input logic [2:0] size);
        logic [6:0]  len;
        logic [6:0]  room;
        logic [63:0] ones;
        len  = {1'b0, size, 3'b000};
        room = hi ? 7'd32 : 7'd64;
        if (len > room) len = room;
        if (len >= 7'd64) ones = '1;
        else              ones = (64'd1 << len) - 64'd1;
        return hi ? (ones << 32) : ones;
    endfunction

    function automatic logic [63:0] merge_field(input logic [63:0] old_v,
                                                input logic [63:0] new_v,
                                                input logic [63:0] fmask,
                                                input logic [63:0] wmask);
        logic [63:0] m;
        m = fmask & wmask;
        return (old_v & ~m) | (new_v & m);
    endfunction

endpackage

// File: rtl/evt_addr_decode.sv
module evt_addr_decode
    import evt_pkg::*;
#(
    parameter int N = 3
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [2:0]        size,
    output acc_dec_t          dec
);
    logic [ADDR_W-1:0] base_addr;
    logic [ADDR_W-1:0] slot_off;
    logic [IDX_W-1:0]  idx;

    always_comb begin
        base_addr    = addr;
        base_addr[2] = 1'b0;
        slot_off     = base_addr - ADDR_W'(10'h100);
        idx          = slot_off[ADDR_W-1:5];

        dec.hi    = addr[2];
        dec.fmask = field_mask(addr[2], size);
        dec.tidx  = '0;
        dec.sel   = SEL_NONE;

        if (base_addr[ADDR_W-1:8] == '0) begin
            case (base_addr[7:0])
                8'h00:   dec.sel = SEL_IDENT;
                8'h10:   dec.sel = SEL_GCTL;
                8'h20:   dec.sel = SEL_STAT;
                8'hF0:   dec.sel = SEL_COUNT;
                default: dec.sel = SEL_NONE;
            endcase
        end else if (int'(idx) < N) begin
            dec.tidx = idx;
            case (slot_off[4:0])
                5'h00:   dec.sel = SEL_TCTL;
                5'h08:   dec.sel = SEL_TCMP;
                5'h10:   dec.sel = SEL_TROUTE;
                default: dec.sel = SEL_NONE;
            endcase
        end
    end

endmodule

// File: rtl/evt_main_counter.sv
module evt_main_counter
    import evt_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        run,
    input  logic        wr,
    input  logic [63:0] wval,
    input  logic [63:0] fmask,
    output logic [63:0] count
);
    logic [63:0] cnt_d;
    logic [63:0] cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (run)     cnt_d = cnt_q + 64'd1;
        else if (wr) cnt_d = merge_field(cnt_q, wval, fmask, FULL_WMASK);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign count = cnt_q;

endmodule

// File: rtl/evt_timer_slot.sv
module evt_timer_slot
    import evt_pkg::*;
#(
    parameter logic [31:0] ROUTE_CAP = 32'h0000_00F0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_ctl,
    input  logic        wr_cmp,
    input  logic        wr_route,
    input  logic [63:0] wval,
    input  logic [63:0] fmask,
    output logic [63:0] ctl,
    output logic [63:0] cmp,
    output logic [63:0] route
);
    localparam logic [63:0] CTL_FIXED = {ROUTE_CAP, 32'h0000_0030};

    typedef struct packed {
        logic [63:0] ctl;
        logic [63:0] cmp;
        logic [63:0] route;
    } slot_t;

    slot_t slot_d;
    slot_t slot_q;

    always_comb begin
        slot_d = slot_q;
        if (wr_ctl)
            slot_d.ctl = (merge_field(slot_q.ctl, wval, fmask, TCFG_WMASK) & TCFG_WMASK)
                         | CTL_FIXED;
        if (wr_cmp)
            slot_d.cmp = merge_field(slot_q.cmp, wval, fmask, FULL_WMASK);
        if (wr_route)
            slot_d.route = merge_field(slot_q.route, wval, fmask, FULL_WMASK);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slot_q.ctl   <= CTL_FIXED;
            slot_q.cmp   <= '0;
            slot_q.route <= '0;
        end else begin
            slot_q <= slot_d;
        end
    end

    assign ctl   = slot_q.ctl;
    assign cmp   = slot_q.cmp;
    assign route = slot_q.route;

endmodule

// File: rtl/evt_timer_regs.sv
module evt_timer_regs
    import evt_pkg::*;
#(
    parameter int          N         = 3,
    parameter logic [31:0] TICK_FS   = 32'd10_000_000,
    parameter logic [31:0] ROUTE_CAP = 32'h0000_00F0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_rd,
    input  logic                bus_wr,
    input  logic [2:0]          bus_size,
    input  logic [31:0]         bus_wdata,
    input  logic [N-1:0]        tmr_hit,
    output logic [31:0]         bus_rdata,
    output logic                tmr_run,
    output logic                tmr_legacy,
    output logic [63:0]         main_count,
    output logic [64*N-1:0]     tmr_cfg_flat,
    output logic [64*N-1:0]     tmr_cmp_flat,
    output logic [64*N-1:0]     tmr_route_flat
);
    localparam logic [63:0] IDENT_VAL = {TICK_FS, 32'h0000_0001};
    localparam logic [63:0] STAT_MASK = (64'd1 << N) - 64'd1;

    typedef struct packed {
        logic [63:0] gctl;
        logic [63:0] stat;
        logic [31:0] rdata;
    } top_t;

    top_t st_d;
    top_t st_q;

    acc_dec_t    dec;
    logic [63:0] wval;
    logic [63:0] count_w;
    logic [63:0] ctl_w   [N];
    logic [63:0] cmp_w   [N];
    logic [63:0] route_w [N];
    logic [63:0] rd64;
    logic [63:0] clr_bits;

    evt_addr_decode #(.N(N)) u_dec (
        .addr (bus_addr),
        .size (bus_size),
        .dec  (dec)
    );

    assign wval = dec.hi ? {bus_wdata, 32'h0} : {32'h0, bus_wdata};

    evt_main_counter u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (st_q.gctl[0]),
        .wr    (bus_wr && (dec.sel == SEL_COUNT)),
        .wval  (wval),
        .fmask (dec.fmask),
        .count (count_w)
    );

    for (genvar i = 0; i < N; i++) begin : g_slot
        logic hit_me;
        assign hit_me = bus_wr && (int'(dec.tidx) == i);

        evt_timer_slot #(.ROUTE_CAP(ROUTE_CAP)) u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_ctl   (hit_me && (dec.sel == SEL_TCTL)),
            .wr_cmp   (hit_me && (dec.sel == SEL_TCMP)),
            .wr_route (hit_me && (dec.sel == SEL_TROUTE)),
            .wval     (wval),
            .fmask    (dec.fmask),
            .ctl      (ctl_w[i]),
            .cmp      (cmp_w[i]),
            .route    (route_w[i])
        );

        assign tmr_cfg_flat[64*i +: 64]   = ctl_w[i];
        assign tmr_cmp_flat[64*i +: 64]   = cmp_w[i];
        assign tmr_route_flat[64*i +: 64] = route_w[i];
    end

    always_comb begin
        rd64 = '0;
        case (dec.sel)
            SEL_IDENT: rd64 = IDENT_VAL;
            SEL_GCTL:  rd64 = st_q.gctl;
            SEL_STAT:  rd64 = st_q.stat;
            SEL_COUNT: rd64 = count_w;
            SEL_TCTL, SEL_TCMP, SEL_TROUTE: begin
                for (int i = 0; i < N; i++) begin
                    if (int'(dec.tidx) == i) begin
                        if (dec.sel == SEL_TCTL)      rd64 = ctl_w[i];
                        else if (dec.sel == SEL_TCMP) rd64 = cmp_w[i];
                        else                          rd64 = route_w[i];
                    end
                end
            end
            default:   rd64 = '0;
        endcase
    end

    always_comb begin
        st_d = st_q;

        if (bus_wr && (dec.sel == SEL_GCTL))
            st_d.gctl = merge_field(st_q.gctl, wval, dec.fmask, GCFG_WMASK) & GCFG_WMASK;

        clr_bits = '0;
        if (bus_wr && (dec.sel == SEL_STAT))
            clr_bits = wval & dec.fmask & STAT_MASK;
        st_d.stat = ((st_q.stat & ~clr_bits) | {{(64-N){1'b0}}, tmr_hit}) & STAT_MASK;

        if (bus_rd)
            st_d.rdata = dec.hi ? rd64[63:32] : rd64[31:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bus_rdata  = st_q.rdata;
    assign tmr_run    = st_q.gctl[0];
    assign tmr_legacy = st_q.gctl[1];
    assign main_count = count_w;

endmodule

// File: rtl/evt_timer_regs_chk.sv
module evt_timer_regs_chk
    import evt_pkg::*;
#(
    parameter int          N       = 3,
    parameter logic [31:0] TICK_FS = 32'd10_000_000
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_rd,
    input logic              bus_wr,
    input logic [2:0]        bus_size,
    input logic [31:0]       bus_wdata,
    input logic [31:0]       bus_rdata,
    input logic              tmr_run,
    input logic [63:0]       main_count
);
    localparam int FIRST_BAD = 256 + 32 * N;

    // R1: data holds without a read strobe
    a_r1_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));

    // R2: identity words
    a_r2_ident_low: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == 10'h000) |=> bus_rdata == 32'h0000_0001);

    a_r2_ident_high: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == 10'h004) |=> bus_rdata == TICK_FS);

    // R3: run bit follows a written control low word
    a_r3_run_write: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 10'h010 && bus_size != 3'd0)
        |=> tmr_run == $past(bus_wdata[0]));

    // R7: beyond the last timer reads zero
    a_r7_unmapped_read: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && int'(bus_addr) >= FIRST_BAD) |=> bus_rdata == 32'h0);

    // R9: running count advances
    a_r9_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_run |=> main_count == $past(main_count) + 64'd1);

    // R10: stopped count holds without writes
    a_r10_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!tmr_run && !bus_wr) |=> $stable(main_count));

endmodule

bind evt_timer_regs evt_timer_regs_chk #(.N(N), .TICK_FS(TICK_FS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (bus_addr),
    .bus_rd     (bus_rd),
    .bus_wr     (bus_wr),
    .bus_size   (bus_size),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .tmr_run    (tmr_run),
    .main_count (main_count)
);

// File: tb/evt_timer_regs_bench.sv
module evt_timer_regs_bench;
    localparam int N = 3;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [9:0]     bus_addr = '0;
    logic           bus_rd = 1'b0;
    logic           bus_wr = 1'b0;
    logic [2:0]     bus_size = 3'd4;
    logic [31:0]    bus_wdata = '0;
    logic [N-1:0]   tmr_hit = '0;
    logic [31:0]    bus_rdata;
    logic           tmr_run;
    logic           tmr_legacy;
    logic [63:0]    main_count;
    logic [64*N-1:0] tmr_cfg_flat;
    logic [64*N-1:0] tmr_cmp_flat;
    logic [64*N-1:0] tmr_route_flat;

    int total = 0;
    int bad = 0;

    typedef struct {
        logic [31:0] exp;
        string       tag;
    } exp_t;
    exp_t sb[$];
    logic rd_seen = 1'b0;

    always #5 clk = ~clk;

    evt_timer_regs u_evt_timer_regs (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_size(bus_size), .bus_wdata(bus_wdata),
        .tmr_hit(tmr_hit), .bus_rdata(bus_rdata), .tmr_run(tmr_run),
        .tmr_legacy(tmr_legacy), .main_count(main_count),
        .tmr_cfg_flat(tmr_cfg_flat), .tmr_cmp_flat(tmr_cmp_flat),
        .tmr_route_flat(tmr_route_flat)
    );

    always @(posedge clk) rd_seen <= bus_rd;

    // monitor: one expected item per read strobe, checked after the edge
    always @(negedge clk) begin
        if (rd_seen) begin
            exp_t e;
            total++;
            if (sb.size() == 0) begin
                bad++;
                $display("FAIL %s: no expected item, actual=%h", "scoreboard", bus_rdata);
            end else begin
                e = sb.pop_front();
                if (bus_rdata !== e.exp) begin
                    bad++;
                    $display("FAIL %s: actual=%h expected=%h", e.tag, bus_rdata, e.exp);
                end
            end
        end
    end

    task automatic do_rd(input logic [9:0] a, input logic [31:0] exp, input string tag);
        exp_t e;
        e.exp = exp;
        e.tag = tag;
        sb.push_back(e);
        bus_addr = a;
        bus_rd   = 1'b1;
        @(negedge clk);
        bus_rd   = 1'b0;
    endtask

    task automatic do_wr(input logic [9:0] a, input logic [31:0] d, input logic [2:0] sz);
        bus_addr  = a;
        bus_wdata = d;
        bus_size  = sz;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
        bus_size  = 3'd4;
    endtask

    task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string tag);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11 reset state
        do_rd(10'h010, 32'h0, "R11 control reset");
        do_rd(10'h020, 32'h0, "R11 status reset");
        do_rd(10'h100, 32'h0000_0030, "R11 timer0 control low reset");
        do_rd(10'h104, 32'h0000_00F0, "R11 timer0 control high reset");
        do_rd(10'h148, 32'h0, "R11 timer2 compare reset");
        do_rd(10'h0F0, 32'h0, "R11 count reset");

        // R2 identity, read-only
        do_rd(10'h000, 32'h0000_0001, "R2 identity low");
        do_rd(10'h004, 32'h0098_9680, "R2 identity high");
        do_wr(10'h000, 32'hFFFF_FFFF, 3'd4);
        do_rd(10'h000, 32'h0000_0001, "R2 identity after write");

        // R3 global control mask
        do_wr(10'h010, 32'hFFFF_FFFE, 3'd4);
        do_rd(10'h010, 32'h0000_0002, "R3 control masked");
        chk({63'b0, tmr_legacy}, 64'd1, "R3 legacy pin");
        chk({63'b0, tmr_run}, 64'd0, "R3 run pin");
        do_wr(10'h014, 32'hFFFF_FFFF, 3'd4);
        do_rd(10'h014, 32'h0, "R3 control high reads zero");
        do_wr(10'h010, 32'h0, 3'd4);

        // R5 timer control mask and read-only bits
        do_wr(10'h100, 32'hFFFF_FFFF, 3'd4);
        do_wr(10'h104, 32'h0, 3'd4);
        do_rd(10'h100, 32'h0000_7F7E, "R5 control write mask");
        do_rd(10'h104, 32'h0000_00F0, "R5 capability high fixed");

        // R4 and R1 slot decode and halves
        do_wr(10'h128, 32'h1122_3344, 3'd4);
        do_wr(10'h12C, 32'h5566_7788, 3'd4);
        do_wr(10'h150, 32'hCAFE_0001, 3'd4);
        do_rd(10'h128, 32'h1122_3344, "R4 timer1 compare low");
        do_rd(10'h12C, 32'h5566_7788, "R1 timer1 compare high");
        do_rd(10'h150, 32'hCAFE_0001, "R4 timer2 route");
        do_rd(10'h108, 32'h0, "R4 timer0 compare untouched");
        chk(tmr_cmp_flat[64 +: 64], 64'h5566_7788_1122_3344, "R4 timer1 compare pin");

        // R6 partial writes
        do_wr(10'h128, 32'hFFFF_FFAB, 3'd1);
        do_rd(10'h128, 32'h1122_33AB, "R6 byte write");
        do_wr(10'h12C, 32'h1234_BEEF, 3'd2);
        do_rd(10'h12C, 32'h5566_BEEF, "R6 half write upper word");

        // R7 unmapped
        do_wr(10'h118, 32'hFFFF_FFFF, 3'd4);
        do_rd(10'h118, 32'h0, "R7 slot hole read");
        do_rd(10'h110, 32'h0, "R7 neighbour route untouched");
        do_wr(10'h168, 32'hFFFF_FFFF, 3'd4);
        do_rd(10'h168, 32'h0, "R7 index beyond N");
        do_rd(10'h030, 32'h0, "R7 global hole");

        // R8 status
        tmr_hit = 3'b101;
        @(negedge clk);
        tmr_hit = '0;
        do_rd(10'h020, 32'h5, "R8 status set");
        do_wr(10'h020, 32'h1, 3'd4);
        do_rd(10'h020, 32'h4, "R8 clear by one");
        do_wr(10'h020, 32'h0, 3'd4);
        do_rd(10'h020, 32'h4, "R8 zero leaves");
        bus_addr = 10'h020; bus_wdata = 32'h4; bus_wr = 1'b1; tmr_hit = 3'b100;
        @(negedge clk);
        bus_wr = 1'b0; tmr_hit = '0;
        do_rd(10'h020, 32'h4, "R8 set wins");
        do_wr(10'h020, 32'hFF, 3'd4);
        do_rd(10'h020, 32'h0, "R8 clear all");

        // R10 load while stopped
        do_wr(10'h0F0, 32'd100, 3'd4);
        do_wr(10'h0F4, 32'd0, 3'd4);
        do_rd(10'h0F0, 32'd100, "R10 stored count");

        // R9 running: run strobe, 4 idle edges, read strobe on the 5th
        do_wr(10'h010, 32'h1, 3'd4);
        repeat (4) @(negedge clk);
        do_rd(10'h0F0, 32'd104, "R9 live count");
        do_wr(10'h0F0, 32'd5, 3'd4);
        do_wr(10'h010, 32'h0, 3'd4);
        do_rd(10'h0F0, 32'd107, "R10 write ignored while running");
        do_rd(10'h0F4, 32'd0, "R10 count high");
        repeat (3) @(negedge clk);
        do_rd(10'h0F0, 32'd107, "R10 count frozen");

        @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule